// File: doc/BRIEF.md
# Byte Write-Protect Memory Controller

This controller owns a 1024-byte store in which every byte carries a one-time-programmable lock flag. A serial front end decodes command frames and presents each one here as a 6-bit opcode, a 10-bit byte address and an 8-bit data byte. The block serves two kinds of read. One returns the byte alone. The other returns the byte together with its lock flag. It also serves three programming commands: an erase-then-write that leaves the lock alone, an erase-then-write that also locks the byte, and a lock command that takes effect only when the supplied byte equals the stored one.

A lock flag is active-low. Once it is cleared, nothing sets it again, and later writes to that byte change nothing. Every programming command occupies the block for a parameterised programming interval. During that interval `busy` is high and all new commands are dropped. After each reset, programming commands are refused until one read has been served. The store itself is a register array that reset returns to the erased state.

Top module: `wp_mem_ctrl`

## Requirements
- R1: After reset `busy` and `rd_valid` are low, every byte reads 0xFF and every lock flag reads 1 (unlocked).
- R2: The opcode takes `cmd_op[5]` as the first command bit and `cmd_op[0]` as the last. The codes are 6'b011100 for a byte read, 6'b001100 for a byte-plus-flag read, 6'b110011 for a write, 6'b100011 for a write-and-lock and 6'b000011 for a compare-and-lock.
- R3: A byte read accepted at a clock edge raises `rd_valid` for exactly the next cycle. In that cycle `rd_data` holds the stored byte, `rd_wide` is 0 and `rd_prot_n` is 1.
- R4: A byte-plus-flag read behaves the same way, except that `rd_wide` is 1 and `rd_prot_n` carries the byte's lock flag as the ninth bit.
- R5: An accepted programming command holds `busy` high for exactly PROG_CYCLES cycles, starting in the cycle after acceptance. A write to an unlocked byte makes the new data visible to reads after `busy` falls, and it leaves the lock flag at 1.
- R6: A write-and-lock to an unlocked byte stores the data and clears its lock flag.
- R7: A write or write-and-lock aimed at a locked byte leaves the byte unchanged, yet it still holds `busy` for PROG_CYCLES cycles.
- R8: Compare-and-lock clears the lock flag only when `cmd_data` equals the stored byte. The byte itself never changes. On a mismatch the flag keeps its value.
- R9: A cleared lock flag never returns to 1, whatever command follows.
- R10: After reset, programming commands are ignored until one read has been accepted. An ignored command raises no `busy` and changes no byte and no flag.
- R11: Commands presented while `busy` is high are ignored. They produce no `rd_valid` and cause no change.
- R12: An opcode that is none of the five codes is ignored. It produces no `busy`, no `rd_valid` and no change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 6 | Command opcode, first command bit in bit 5 |
| cmd_addr | input | 10 | Byte address |
| cmd_data | input | 8 | Write or compare data |
| busy | output | 1 | Programming interval in progress |
| rd_valid | output | 1 | Read result valid (one cycle) |
| rd_data | output | 8 | Byte read |
| rd_prot_n | output | 1 | Lock flag on wide reads, 1 on byte reads |
| rd_wide | output | 1 | Result came from a byte-plus-flag read |

## Verification
A read result is due one cycle after its accepting edge, so the bench samples `rd_valid` and the data fields at the falling edge that follows that edge. `busy` is first high at that same falling edge and stays high for PROG_CYCLES samples. A programming command's effect becomes visible only through a read issued after `busy` has fallen. The bench's behavioural model advances on each rising edge, and all outputs are compared with it at every falling edge. Directed checks then confirm the fixed expected constants and the busy window length.

// File: rtl/wpm_pkg.sv
// Package: shared command kinds and opcode values for the write-protect
// memory controller. Assumes opcode bit 5 is the first command bit.
package wpm_pkg;

    localparam logic [5:0] OP_RD8  = 6'b011100;
    localparam logic [5:0] OP_RD9  = 6'b001100;
    localparam logic [5:0] OP_WR   = 6'b110011;
    localparam logic [5:0] OP_WRP  = 6'b100011;
    localparam logic [5:0] OP_CMPP = 6'b000011;

    typedef enum logic [2:0] {
        K_NONE = 3'd0,
        K_RD8  = 3'd1,
        K_RD9  = 3'd2,
        K_WR   = 3'd3,
        K_WRP  = 3'd4,
        K_CMPP = 3'd5
    } cmd_kind_e;

endpackage

// File: rtl/wpm_decode.sv
// Module: opcode decoder. Maps a 6-bit opcode to a command kind; every
// unlisted code maps to K_NONE. Purely combinational.
module wpm_decode
    import wpm_pkg::*;
(
    input  logic [5:0] op,
    output cmd_kind_e  kind,
    output logic       is_read,
    output logic       is_prog
);

    // Opcode to kind lookup.
    always_comb begin
        unique case (op)
            OP_RD8:  kind = K_RD8;
            OP_RD9:  kind = K_RD9;
            OP_WR:   kind = K_WR;
            OP_WRP:  kind = K_WRP;
            OP_CMPP: kind = K_CMPP;
            default: kind = K_NONE;
        endcase
    end

    // Class flags used by the sequencer.
    always_comb begin
        is_read = (kind == K_RD8) || (kind == K_RD9);
        is_prog = (kind == K_WR) || (kind == K_WRP) || (kind == K_CMPP);
    end

endmodule

// File: rtl/wpm_sequencer.sv
// Module: command sequencer. Accepts a command when idle, gates programming
// on a read having been served since reset, runs the programming interval
// and emits a one-cycle commit at its last busy cycle.
// Assumes PROG_CYCLES >= 1.
module wpm_sequencer
    import wpm_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  cmd_kind_e         kind,
    input  logic              is_read,
    input  logic              is_prog,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              rd_start,
    output logic              commit,
    output cmd_kind_e         c_kind,
    output logic [ADDR_W-1:0] c_addr,
    output logic [DATA_W-1:0] c_data
);

    localparam int CNT_W = $clog2(PROG_CYCLES + 1);

    logic             busy_q;
    logic             read_seen;
    logic [CNT_W-1:0] cnt;
    logic             accept;
    logic             prog_start;

    // Acceptance and start qualifiers.
    always_comb begin
        accept     = cmd_valid && !busy_q;
        rd_start   = accept && is_read;
        prog_start = accept && is_prog && read_seen;
        commit     = busy_q && (cnt == '0);
        busy       = busy_q;
    end

    // Read-seen flag, busy window counter and command latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            read_seen <= 1'b0;
            cnt       <= '0;
            c_kind    <= K_NONE;
            c_addr    <= '0;
            c_data    <= '0;
        end else begin
            if (rd_start) begin
                read_seen <= 1'b1;
            end
            if (prog_start) begin
                busy_q <= 1'b1;
                cnt    <= CNT_W'(PROG_CYCLES - 1);
                c_kind <= kind;
                c_addr <= cmd_addr;
                c_data <= cmd_data;
            end else if (busy_q) begin
                if (cnt == '0) begin
                    busy_q <= 1'b0;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/wpm_store.sv
// Module: byte store with one active-low lock flag per byte. Read port is
// combinational; commit applies one programming command. Reset returns all
// bytes to 0xFF and all flags to 1. A flag is only ever written to 0.
module wpm_store
    import wpm_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_byte,
    output logic              rd_flag,
    input  logic              commit,
    input  cmd_kind_e         c_kind,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [DATA_W-1:0] c_data,
    output logic [DEPTH-1:0]  prot_vec
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  prot_n;
    logic [DATA_W-1:0] cur_byte;
    logic              cur_open;

    // Combinational read and target lookup.
    always_comb begin
        rd_byte  = mem[rd_addr];
        rd_flag  = prot_n[rd_addr];
        cur_byte = mem[c_addr];
        cur_open = prot_n[c_addr];
        prot_vec = prot_n;
    end

    // Byte contents: erase-then-write only on an unlocked target.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '1;
            end
        end else if (commit && cur_open &&
                     (c_kind == K_WR || c_kind == K_WRP)) begin
            mem[c_addr] <= c_data;
        end
    end

    // Lock flags: cleared by write-and-lock or by a matching compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_n <= '1;
        end else if (commit) begin
            if ((c_kind == K_WRP && cur_open) ||
                (c_kind == K_CMPP && cur_byte == c_data)) begin
                prot_n[c_addr] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/wp_mem_ctrl.sv
// Module: top of the byte write-protect memory controller. Decodes the
// command, sequences it, and registers read results for one cycle.
// Assumes commands arrive already deserialised, one per cycle at most.
module wp_mem_ctrl
    import wpm_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 625000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [5:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [DATA_W-1:0] cmd_data,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_prot_n,
    output logic              rd_wide
);

    localparam int DEPTH = 1 << ADDR_W;

    cmd_kind_e         kind;
    cmd_kind_e         c_kind;
    logic              is_read;
    logic              is_prog;
    logic              rd_start;
    logic              commit;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;
    logic [DATA_W-1:0] st_byte;
    logic              st_flag;
    logic [DEPTH-1:0]  prot_vec;

    wpm_decode u_dec (
        .op      (cmd_op),
        .kind    (kind),
        .is_read (is_read),
        .is_prog (is_prog)
    );

    wpm_sequencer #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .kind      (kind),
        .is_read   (is_read),
        .is_prog   (is_prog),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .busy      (busy),
        .rd_start  (rd_start),
        .commit    (commit),
        .c_kind    (c_kind),
        .c_addr    (c_addr),
        .c_data    (c_data)
    );

    wpm_store #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_addr  (cmd_addr),
        .rd_byte  (st_byte),
        .rd_flag  (st_flag),
        .commit   (commit),
        .c_kind   (c_kind),
        .c_addr   (c_addr),
        .c_data   (c_data),
        .prot_vec (prot_vec)
    );

    // Read result register: valid for the cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_data   <= '0;
            rd_prot_n <= 1'b1;
            rd_wide   <= 1'b0;
        end else begin
            rd_valid <= rd_start;
            if (rd_start) begin
                rd_data   <= st_byte;
                rd_wide   <= (kind == K_RD9);
                rd_prot_n <= (kind == K_RD9) ? st_flag : 1'b1;
            end
        end
    end

endmodule

// File: rtl/wpm_checker.sv
// Module: property checker for wp_mem_ctrl, bound to every instance.
// Tracks the busy run length and the read-seen condition on its own.
module wpm_checker
    import wpm_pkg::*;
#(
    parameter int PROG_CYCLES = 625000,
    parameter int DEPTH       = 1024
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid,
    input logic [5:0]       cmd_op,
    input logic             busy,
    input logic             rd_valid,
    input logic             rd_wide,
    input logic             rd_prot_n,
    input logic [DEPTH-1:0] prot_vec
);

    int   run;
    logic seen;
    logic op_read;
    logic op_prog;

    // Opcode classes seen from the port.
    always_comb begin
        op_read = (cmd_op == OP_RD8) || (cmd_op == OP_RD9);
        op_prog = (cmd_op == OP_WR) || (cmd_op == OP_WRP) || (cmd_op == OP_CMPP);
    end

    // Busy run length and read-seen tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= 0;
            seen <= 1'b0;
        end else begin
            run <= busy ? run + 1 : 0;
            if (cmd_valid && !busy && op_read) seen <= 1'b1;
        end
    end

    assert_busy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> run < PROG_CYCLES);

    assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> run == PROG_CYCLES);

    assert_prog_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && op_prog && seen) |=> busy);

    assert_rd8_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_RD8) |=> (rd_valid && !rd_wide && rd_prot_n));

    assert_rd9_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == OP_RD9) |=> (rd_valid && rd_wide));

    assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($countones(prot_vec) <= $past($countones(prot_vec))));

    assert_read_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !seen) |=> !busy);

    assert_busy_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> !rd_valid);

    assert_unknown_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && !op_read && !op_prog) |=> (!busy && !rd_valid));

endmodule

bind wp_mem_ctrl wpm_checker #(
    .PROG_CYCLES (PROG_CYCLES),
    .DEPTH       (DEPTH)
) u_wpm_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .rd_wide   (rd_wide),
    .rd_prot_n (rd_prot_n),
    .prot_vec  (prot_vec)
);

// File: tb/tb_wp_mem_ctrl.sv
module tb_wp_mem_ctrl;

    localparam int P = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [5:0] cmd_op = '0;
    logic [9:0] cmd_addr = '0;
    logic [7:0] cmd_data = '0;
    logic       busy, rd_valid, rd_prot_n, rd_wide;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";
    bit   cmp_en = 0;
    bit   done = 0;

    // reference model state
    int  m_mem [1024];
    bit  m_prot [1024];
    bit  m_seen;
    int  m_busy;
    int  m_kind, m_addr, m_data;
    bit  e_valid, e_wide, e_prot;
    int  e_data;

    // captured outputs from the last send
    bit  c_valid, c_wide, c_prot, c_busy;
    int  c_data;

    always #4 clk = ~clk;

    wp_mem_ctrl #(.PROG_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_prot_n(rd_prot_n),
        .rd_wide(rd_wide)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int kind_of(logic [5:0] op);
        if (op == 6'b011100) return 1;
        if (op == 6'b001100) return 2;
        if (op == 6'b110011) return 3;
        if (op == 6'b100011) return 4;
        if (op == 6'b000011) return 5;
        return 0;
    endfunction

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) begin m_mem[i] = 8'hFF; m_prot[i] = 1; end
            m_seen = 0; m_busy = 0; e_valid = 0; e_wide = 0; e_prot = 1; e_data = 0;
        end else begin
            int k;
            k = kind_of(cmd_op);
            e_valid = 0;
            if (m_busy > 0) begin
                m_busy--;
                if (m_busy == 0) begin
                    if ((m_kind == 3 || m_kind == 4) && m_prot[m_addr]) begin
                        m_mem[m_addr] = m_data;
                        if (m_kind == 4) m_prot[m_addr] = 0;
                    end
                    if (m_kind == 5 && m_mem[m_addr] == m_data) m_prot[m_addr] = 0;
                end
            end else if (cmd_valid) begin
                if (k == 1 || k == 2) begin
                    m_seen = 1; e_valid = 1; e_data = m_mem[cmd_addr];
                    e_wide = (k == 2); e_prot = (k == 2) ? m_prot[cmd_addr] : 1'b1;
                end else if (k >= 3 && m_seen) begin
                    m_busy = P; m_kind = k; m_addr = cmd_addr; m_data = cmd_data;
                end
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk({cur_req, " busy"}, busy, m_busy > 0);
            chk({cur_req, " rd_valid"}, rd_valid, e_valid);
            if (e_valid) begin
                chk({cur_req, " rd_data"}, rd_data, e_data);
                chk({cur_req, " rd_wide"}, rd_wide, e_wide);
                chk({cur_req, " rd_prot_n"}, rd_prot_n, e_prot);
            end
        end
    end

    // present one command for one cycle, capture outputs one cycle later
    task automatic send(logic [5:0] op, int a, int d);
        cmd_valid = 1; cmd_op = op; cmd_addr = 10'(a); cmd_data = 8'(d);
        @(negedge clk);
        c_valid = rd_valid; c_data = rd_data; c_wide = rd_wide;
        c_prot = rd_prot_n; c_busy = busy;
        cmd_valid = 0; cmd_op = '0; cmd_addr = '0; cmd_data = '0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic count_busy(string req);
        int n = 0;
        while (busy) begin n++; @(negedge clk); end
        chk(req, n, P);
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        @(negedge clk);
        cmp_en = 1;
        do_reset();
        chk("R1 busy after reset", busy, 0);
        chk("R1 rd_valid after reset", rd_valid, 0);

        // R10: write before any read is dropped
        cur_req = "R10";
        send(6'b110011, 5, 8'h12);
        chk("R10 no busy", c_busy, 0);
        @(negedge clk);

        // R1 / R4: erased content on a wide read
        cur_req = "R4";
        send(6'b001100, 0, 0);
        chk("R1 erased byte", c_data, 8'hFF);
        chk("R1 unlocked flag", c_prot, 1);
        chk("R4 wide", c_wide, 1);
        send(6'b011100, 5, 0);
        chk("R10 byte unchanged", c_data, 8'hFF);

        // R12: unknown code
        cur_req = "R12";
        send(6'b111111, 5, 8'h00);
        chk("R12 no busy", c_busy, 0);
        chk("R12 no read", c_valid, 0);

        // R5: write and busy window
        cur_req = "R5";
        send(6'b110011, 5, 8'h12);
        count_busy("R5 busy length");
        send(6'b011100, 5, 0);
        chk("R5 data", c_data, 8'h12);
        chk("R3 rd_wide low", c_wide, 0);
        chk("R3 rd_prot_n high", c_prot, 1);
        send(6'b001100, 5, 0);
        chk("R5 flag kept", c_prot, 1);

        // R11: commands during busy are dropped
        cur_req = "R11";
        send(6'b110011, 9, 8'h3C);
        send(6'b011100, 9, 0);
        chk("R11 no read while busy", c_valid, 0);
        send(6'b110011, 7, 8'h00);
        wait_idle();
        send(6'b011100, 7, 0);
        chk("R11 dropped write", c_data, 8'hFF);
        send(6'b011100, 9, 0);
        chk("R11 first write landed", c_data, 8'h3C);

        // R6: write and lock at top address
        cur_req = "R6";
        send(6'b100011, 1023, 8'hA5);
        count_busy("R6 busy length");
        send(6'b001100, 1023, 0);
        chk("R6 data", c_data, 8'hA5);
        chk("R6 locked", c_prot, 0);

        // R7 / R9: writes to locked byte
        cur_req = "R7";
        send(6'b110011, 1023, 8'h00);
        count_busy("R7 busy length");
        send(6'b100011, 1023, 8'h11);
        wait_idle();
        send(6'b001100, 1023, 0);
        chk("R7 data kept", c_data, 8'hA5);
        chk("R9 flag stays 0", c_prot, 0);
        send(6'b011100, 1023, 0);
        chk("R3 byte read of locked byte", c_prot, 1);

        // R8: compare-and-lock
        cur_req = "R8";
        send(6'b000011, 5, 8'h13);
        wait_idle();
        send(6'b001100, 5, 0);
        chk("R8 mismatch flag", c_prot, 1);
        chk("R8 mismatch data", c_data, 8'h12);
        send(6'b000011, 5, 8'h12);
        count_busy("R8 busy length");
        send(6'b001100, 5, 0);
        chk("R8 match flag", c_prot, 0);
        chk("R8 match data", c_data, 8'h12);
        send(6'b110011, 5, 8'h77);
        wait_idle();
        send(6'b011100, 5, 0);
        chk("R9 locked write ignored", c_data, 8'h12);

        // R2: all codes with bit 5 first; neighbour code is not a write
        cur_req = "R2";
        send(6'b110010, 11, 8'h44);
        chk("R2 near-miss code no busy", c_busy, 0);

        // R10 again after a fresh reset
        cur_req = "R10";
        do_reset();
        send(6'b100011, 20, 8'h55);
        chk("R10 after reset no busy", c_busy, 0);
        send(6'b001100, 20, 0);
        chk("R10 data erased", c_data, 8'hFF);
        chk("R10 flag open", c_prot, 1);

        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule